// File: doc/BRIEF.md
# SMBus Target with Strapped Addressing

This block is a byte-level SMBus/I2C target for a supervisory device. It runs on a system clock that is at least 16 times faster than SCL. Both bus lines pass through a synchroniser. START, repeated START and STOP are seen as SDA edges while SCL is high. The block only pulls SDA low or releases it. The external pull-ups supply the high level.

Two address-select pins each take three levels: low, floating or high. Each pin is given to the block as a 2-bit code, and the pair picks one of nine 7-bit device addresses. A broadcast address (0x73) is always accepted as if it were the device's own address. The alert response address (0x0C) is answered only while the block is pulling its ALERT line low.

Three transactions are supported against a plain register port. Send Byte raises a command-only strobe. Write Word assembles a 16-bit value and raises a write strobe. Read Word returns a 16-bit value taken from a read-data input. A transaction cut short by an early STOP or START issues no strobe.

Top module: `smb_strap_target`

## Requirements
- R1: Strap codes are 2'b00 low, 2'b01 floating, 2'b10 high, and 2'b11 is treated as floating. The own address is 0x50, 0x51 or 0x52 for select-0 low, floating or high while select-1 is low. It is 0x53 to 0x55 for select-1 floating and 0x58 to 0x5A for select-1 high. A write to the own address is acknowledged.
- R2: The address byte is the 7-bit address followed by the R/W bit, with 1 meaning read. An address byte that matches nothing is not acknowledged. The target then drives neither SDA nor any strobe until the next START.
- R3: Address 0x73 is acknowledged for writes and reads, whatever the strap inputs are.
- R4: A Write Word is command byte, data low byte, then data high byte, each acknowledged. After the high byte, wr_data holds {high, low} and wr_strobe pulses for exactly one cycle with cmd_code equal to the command byte.
- R5: A Send Byte (START, address+W, command, STOP) pulses cmd_strobe once with cmd_code equal to the command byte. wr_strobe does not pulse.
- R6: In a Read Word, the target sends rd_data[7:0] first. It sends rd_data[15:8] after the controller ACKs. rd_data is sampled when the read address is acknowledged.
- R7: An address+R that does not follow a command byte via repeated START is not acknowledged.
- R8: A STOP or START arriving before the data high byte is complete produces no wr_strobe.
- R9: alert_n_oe is asserted while alert_flag and alert_en are both set, unless the alert has already been serviced. A serviced alert re-arms once alert_flag has been low.
- R10: A read of 0x0C while the alert is asserted is acknowledged. The target returns its own address in bits 7:1 with bit 0 equal to 0, then releases the alert. With the alert not asserted, 0x0C is not acknowledged.
- R11: sda_oe only begins pulling SDA low while SCL is low.
- R12: wr_data changes only in a cycle where wr_strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sel0 | input | 2 | Address select 0 strap code |
| sel1 | input | 2 | Address select 1 strap code |
| alert_flag | input | 1 | Fault flag requesting an alert |
| alert_en | input | 1 | Alert enable |
| alert_n_oe | output | 1 | 1 pulls the ALERT line low |
| cmd_code | output | 8 | Command byte of the current transaction |
| cmd_strobe | output | 1 | One-cycle pulse at a completed Send Byte |
| wr_data | output | 16 | Word of the last completed Write Word |
| wr_strobe | output | 1 | One-cycle pulse at a completed Write Word |
| rd_data | input | 16 | Word returned by Read Word |

## Verification
Some properties are checked by assertions on every cycle. Both strobes must be single-cycle and never raised together. wr_data may only move together with its strobe. SDA may only start to be pulled low while SCL is low. The alert line must never be pulled without a fault flag. The byte-level behaviour can only be shown by the bench's bus transactions. This covers the strap-to-address map, the low-byte-first word order, the read that needs a preceding command, the aborted writes, and the alert response with its release and re-arm. Random transactions run over random strap settings and random data.

// File: rtl/smb_pkg.sv
// Package: shared strap codes and the byte-level state type of the SMBus target.
// Assumes the two-bit strap encoding listed in the brief.
package smb_pkg;
    localparam logic [1:0] STRAP_LOW   = 2'b00;
    localparam logic [1:0] STRAP_FLOAT = 2'b01;
    localparam logic [1:0] STRAP_HIGH  = 2'b10;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_CMD, S_DLO, S_DHI, S_END, S_RLO, S_RHI, S_ARA, S_IGN
    } smb_st_t;

    // Maps a strap code to its level index 0 (low), 1 (floating), 2 (high).
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        case (code)
            STRAP_LOW:  strap_level = 2'd0;
            STRAP_HIGH: strap_level = 2'd2;
            default:    strap_level = 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Module: synchroniser for one open-drain bus line, plus a one-cycle delayed copy
// used for edge detection. Assumes the line idles high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= line_i;
            end
        end else begin : g_many
            // Shift chain of capture stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign line_s = chain[STAGES-1];

    // Previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_s;
    end
endmodule

// File: rtl/smb_strap_addr.sv
// Module: turns the two three-level strap codes into the 7-bit own address.
// The nine addresses sit in three rows; the third row starts at 0x58, not 0x56.
module smb_strap_addr (
    input  logic [1:0] sel0,
    input  logic [1:0] sel1,
    output logic [6:0] own_addr
);
    import smb_pkg::*;

    logic [1:0] lvl0, lvl1;
    logic [6:0] row_base;

    // Row base from select-1 and column offset from select-0.
    always_comb begin
        lvl0 = strap_level(sel0);
        lvl1 = strap_level(sel1);
        case (lvl1)
            2'd0:    row_base = 7'h50;
            2'd1:    row_base = 7'h53;
            default: row_base = 7'h58;
        endcase
        own_addr = row_base + {5'd0, lvl0};
    end
endmodule

// File: rtl/smb_strap_target.sv
// Module: SMBus target running Send Byte, Write Word and Read Word against a register
// port, with strapped addressing, a broadcast address and an alert response.
// Assumes clk is at least 16x SCL and the controller changes SDA only while SCL is low.
module smb_strap_target #(
    parameter logic [6:0] GLOBAL_ADDR = 7'h73,
    parameter logic [6:0] ARA_ADDR    = 7'h0C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  sel0,
    input  logic [1:0]  sel1,
    input  logic        alert_flag,
    input  logic        alert_en,
    output logic        alert_n_oe,
    output logic [7:0]  cmd_code,
    output logic        cmd_strobe,
    output logic [15:0] wr_data,
    output logic        wr_strobe,
    input  logic [15:0] rd_data
);
    import smb_pkg::*;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    logic scl_s, scl_q, sda_s, sda_q;
    logic [6:0] own_addr;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_s(scl_s), .line_q(scl_q));
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_s(sda_s), .line_q(sda_q));
    smb_strap_addr u_addr (.sel0(sel0), .sel1(sel1), .own_addr(own_addr));

    smb_st_t           st;
    logic [CNT_W-1:0]  cnt;
    logic              in_ack, ours, ack_bit, rd_ok, ara_mask;
    logic [7:0]        shreg, tx, hi_hold, lo_hold;

    logic start_c, stop_c, scl_rise, scl_fall, tx_state, addr_hit, send_end, alert_act;

    // Bus condition decode and transaction qualifiers.
    always_comb begin
        start_c   = scl_s & scl_q & sda_q & ~sda_s;
        stop_c    = scl_s & scl_q & ~sda_q & sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        tx_state  = (st == S_RLO) || (st == S_RHI) || (st == S_ARA);
        addr_hit  = (shreg[7:1] == own_addr) || (shreg[7:1] == GLOBAL_ADDR);
        send_end  = (st == S_DLO) && !in_ack && (cnt <= CNT_W'(1));
        alert_act = alert_flag & alert_en & ~ara_mask;
    end

    assign alert_n_oe = alert_act;

    // Byte engine: bit shifting, ACK slots, transaction sequencing and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cnt <= '0; in_ack <= 1'b0; ours <= 1'b0; ack_bit <= 1'b1;
            rd_ok <= 1'b0; ara_mask <= 1'b0; sda_oe <= 1'b0;
            shreg <= '0; tx <= '0; hi_hold <= '0; lo_hold <= '0;
            cmd_code <= '0; cmd_strobe <= 1'b0; wr_data <= '0; wr_strobe <= 1'b0;
        end else begin
            wr_strobe  <= 1'b0;
            cmd_strobe <= 1'b0;
            if (!alert_flag) ara_mask <= 1'b0;
            if (start_c) begin
                st <= S_ADDR; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
                rd_ok <= send_end;
            end else if (stop_c) begin
                if (send_end) cmd_strobe <= 1'b1;
                st <= S_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; rd_ok <= 1'b0;
            end else if (st != S_IDLE && st != S_IGN) begin
                if (scl_rise) begin
                    if (in_ack) ack_bit <= sda_s;
                    else if (cnt < CNT_FULL) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + CNT_W'(1);
                    end
                end else if (scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        if (ours) begin
                            sda_oe <= tx_state ? ~tx[7] : 1'b0;
                        end else if (st == S_RLO && !ack_bit) begin
                            st <= S_RHI; tx <= hi_hold; sda_oe <= ~hi_hold[7];
                        end else begin
                            st <= S_IGN; sda_oe <= 1'b0;
                        end
                    end else if (cnt == CNT_FULL) begin
                        in_ack <= 1'b1;
                        if (tx_state) begin
                            ours <= 1'b0; sda_oe <= 1'b0;
                            if (st == S_ARA) ara_mask <= 1'b1;
                        end else begin
                            ours <= 1'b1;
                            case (st)
                                S_ADDR: begin
                                    if (!shreg[0] && addr_hit) begin
                                        sda_oe <= 1'b1; st <= S_CMD;
                                    end else if (shreg[0] && addr_hit && rd_ok) begin
                                        sda_oe <= 1'b1; st <= S_RLO;
                                        tx <= rd_data[7:0]; hi_hold <= rd_data[15:8];
                                    end else if (shreg[0] && shreg[7:1] == ARA_ADDR && alert_act) begin
                                        sda_oe <= 1'b1; st <= S_ARA; tx <= {own_addr, 1'b0};
                                    end else begin
                                        st <= S_IGN; in_ack <= 1'b0;
                                    end
                                end
                                S_CMD: begin
                                    sda_oe <= 1'b1; cmd_code <= shreg; st <= S_DLO;
                                end
                                S_DLO: begin
                                    sda_oe <= 1'b1; lo_hold <= shreg; st <= S_DHI;
                                end
                                S_DHI: begin
                                    sda_oe <= 1'b1; wr_data <= {shreg, lo_hold};
                                    wr_strobe <= 1'b1; st <= S_END;
                                end
                                default: begin
                                    st <= S_IGN; in_ack <= 1'b0;
                                end
                            endcase
                        end
                    end else if (tx_state && cnt != '0) begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_strap_checker.sv
// Module: property checker for the SMBus target, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module smb_strap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        alert_flag,
    input logic        alert_n_oe,
    input logic        cmd_strobe,
    input logic        wr_strobe,
    input logic [15:0] wr_data
);
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_strobe && wr_strobe));

    p_alert_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_n_oe |-> alert_flag);

    p_sda_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    p_wr_data_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data) |-> wr_strobe);
endmodule

bind smb_strap_target smb_strap_checker u_smb_strap_checker (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .alert_flag(alert_flag), .alert_n_oe(alert_n_oe),
    .cmd_strobe(cmd_strobe), .wr_strobe(wr_strobe), .wr_data(wr_data));

// File: tb/smb_strap_target_bench.sv
// Bench: a bit-level SMBus controller model drives directed and random transactions
// and compares the results with values computed from the requirements.
// One time unit is taken as 1 ns, so the clock runs at 125 MHz.
module smb_strap_target_bench;
    localparam int Q = 10;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] sel0 = 2'b00, sel1 = 2'b00;
    logic alert_flag = 1'b0, alert_en = 1'b0;
    logic [15:0] rd_data = 16'h0000;
    logic sda_oe, alert_n_oe, cmd_strobe, wr_strobe;
    logic [7:0] cmd_code;
    logic [15:0] wr_data;
    logic sda_line;

    int vectors = 0, fails = 0;
    int wr_cnt = 0, snd_cnt = 0, drv_cnt = 0;
    logic [15:0] last_wr = '0;
    logic [7:0] last_wcmd = '0, last_scmd = '0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_strap_target u_smb_strap_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .sel0(sel0), .sel1(sel1), .alert_flag(alert_flag), .alert_en(alert_en),
        .alert_n_oe(alert_n_oe), .cmd_code(cmd_code), .cmd_strobe(cmd_strobe),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .rd_data(rd_data));

    // Strobe and drive monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe)  begin wr_cnt++;  last_wr = wr_data; last_wcmd = cmd_code; end
            if (cmd_strobe) begin snd_cnt++; last_scmd = cmd_code; end
            if (sda_oe) drv_cnt++;
        end
    end

    function automatic logic [1:0] lvl(input logic [1:0] c);
        return (c == 2'b00) ? 2'd0 : (c == 2'b10) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [6:0] exp_addr(input logic [1:0] s0, input logic [1:0] s1);
        logic [6:0] base;
        base = (lvl(s1) == 2'd0) ? 7'h50 : (lvl(s1) == 2'd1) ? 7'h53 : 7'h58;
        return base + {5'd0, lvl(s0)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        wr_cnt = 0; snd_cnt = 0; drv_cnt = 0;
    endtask

    task automatic b_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(2);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H / 2);
        ack = !sda_line;
        wt(H / 2); scl_m = 1'b0;
    endtask

    task automatic rx_byte(output logic [7:0] b, input bit nack);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wt(Q); scl_m = 1'b1; wt(H / 2); b = {b[6:0], sda_line}; wt(H / 2); scl_m = 1'b0;
        end
        sda_m = nack; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d,
                            output logic [3:0] acks);
        bit k;
        b_start();
        tx_byte({a, 1'b0}, k); acks[3] = k;
        tx_byte(c, k);         acks[2] = k;
        tx_byte(d[7:0], k);    acks[1] = k;
        tx_byte(d[15:8], k);   acks[0] = k;
        b_stop(); wt(4);
    endtask

    task automatic do_send(input logic [6:0] a, input logic [7:0] c, output logic [1:0] acks);
        bit k;
        b_start();
        tx_byte({a, 1'b0}, k); acks[1] = k;
        tx_byte(c, k);         acks[0] = k;
        b_stop(); wt(4);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] c,
                           output logic [15:0] d, output logic [2:0] acks);
        bit k;
        logic [7:0] lo, hi;
        b_start();
        tx_byte({a, 1'b0}, k); acks[2] = k;
        tx_byte(c, k);         acks[1] = k;
        b_start();
        tx_byte({a, 1'b1}, k); acks[0] = k;
        rx_byte(lo, 1'b0);
        rx_byte(hi, 1'b1);
        b_stop(); wt(4);
        d = {hi, lo};
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Stimulus and checks.
    initial begin
        logic [3:0] a4;
        logic [2:0] a3;
        logic [1:0] a2;
        logic [15:0] d;
        logic [7:0] b;
        logic [6:0] own, bad;
        bit k;
        void'($urandom(32'd20240611));
        wt(5); rst_n = 1'b1; wt(5);

        // Reset state.
        chk("reset sda_oe", sda_oe, 0);
        chk("reset R9 alert", alert_n_oe, 0);
        chk("reset strobes", {wr_strobe, cmd_strobe}, 0);

        // R1: every strap combination, including the 2'b11 code.
        for (int s1 = 0; s1 < 4; s1++) begin
            for (int s0 = 0; s0 < 4; s0++) begin
                sel0 = 2'(s0); sel1 = 2'(s1); clr();
                do_send(exp_addr(sel0, sel1), 8'h40 + 8'(s0 * 4 + s1), a2);
                chk("R1 strap address ack", a2, 2'b11);
                chk("R5 send strobe", snd_cnt, 1);
            end
        end

        // R3: broadcast write and read.
        sel0 = 2'b10; sel1 = 2'b01; clr();
        do_write(7'h73, 8'h05, 16'hBEEF, a4);
        chk("R3 global write acks", a4, 4'hF);
        chk("R3 global write data", last_wr, 16'hBEEF);
        rd_data = 16'h1234;
        do_read(7'h73, 8'h06, d, a3);
        chk("R3 global read", {a3, d}, {3'b111, 16'h1234});

        // R7: read without a command byte first.
        clr();
        b_start(); tx_byte({exp_addr(sel0, sel1), 1'b1}, k); b_stop(); wt(4);
        chk("R7 bare read nack", k, 0);
        chk("R7 no drive", drv_cnt, 0);

        // R8: STOP after the low byte, then repeated START after the low byte.
        own = exp_addr(sel0, sel1); clr();
        b_start(); tx_byte({own, 1'b0}, k); tx_byte(8'h03, k); tx_byte(8'h11, k); b_stop(); wt(4);
        chk("R8 stop abort no wr", wr_cnt, 0);
        chk("R8 stop abort no send", snd_cnt, 0);
        clr();
        b_start(); tx_byte({own, 1'b0}, k); tx_byte(8'h03, k); tx_byte(8'h22, k);
        b_start(); b_stop(); wt(4);
        chk("R8 restart abort no wr", wr_cnt, 0);
        chk("R12 wr_data kept", wr_data, 16'hBEEF);

        // R9: alert gating and enable.
        alert_flag = 1'b1; alert_en = 1'b0; wt(3);
        chk("R9 disabled alert", alert_n_oe, 0);
        alert_en = 1'b1; wt(3);
        chk("R9 enabled alert", alert_n_oe, 1);

        // R10: alert response returns own address then releases.
        b_start(); tx_byte({7'h0C, 1'b1}, k); rx_byte(b, 1'b1); b_stop(); wt(4);
        chk("R10 ara ack", k, 1);
        chk("R10 ara address", b, {own, 1'b0});
        chk("R10 alert released", alert_n_oe, 0);
        b_start(); tx_byte({7'h0C, 1'b1}, k); b_stop(); wt(4);
        chk("R10 ara nack when idle", k, 0);
        alert_flag = 1'b0; wt(3); alert_flag = 1'b1; wt(3);
        chk("R9 alert re-armed", alert_n_oe, 1);
        alert_flag = 1'b0; wt(3);

        // Random transactions over random straps and data.
        for (int n = 0; n < 24; n++) begin
            int kind;
            logic [7:0] c;
            logic [15:0] v;
            sel0 = 2'($urandom % 4); sel1 = 2'($urandom % 4);
            own = exp_addr(sel0, sel1);
            kind = int'($urandom % 4);
            c = 8'($urandom); v = 16'($urandom);
            clr();
            case (kind)
                0: begin
                    do_write(own, c, v, a4);
                    chk("R4 write acks", a4, 4'hF);
                    chk("R4 write data", last_wr, v);
                    chk("R4 write cmd", last_wcmd, c);
                    chk("R4 one strobe", {wr_cnt[7:0], snd_cnt[7:0]}, 16'h0100);
                end
                1: begin
                    do_send(own, c, a2);
                    chk("R5 send acks", a2, 2'b11);
                    chk("R5 send cmd", last_scmd, c);
                    chk("R5 send counts", {wr_cnt[7:0], snd_cnt[7:0]}, 16'h0001);
                end
                2: begin
                    rd_data = v;
                    do_read(own, c, d, a3);
                    chk("R6 read acks", a3, 3'b111);
                    chk("R6 read word", d, v);
                    chk("R6 no strobes", {wr_cnt[7:0], snd_cnt[7:0]}, 16'h0000);
                end
                default: begin
                    bad = 7'($urandom);
                    while (bad == own || bad == 7'h73 || bad == 7'h0C) bad = bad + 7'd1;
                    do_write(bad, c, v, a4);
                    chk("R2 mismatch nack", a4, 4'h0);
                    chk("R2 no drive", drv_cnt, 0);
                    chk("R2 no strobes", {wr_cnt[7:0], snd_cnt[7:0]}, 16'h0000);
                end
            endcase
        end

        done = 1;
        finish_run();
    end
endmodule